// File: doc/BRIEF.md
# UART FIFO Control Register

This block is the write side of the FIFO control location in a 16550-style serial port. The bus writes into it at a fixed offset. Reads at that offset are served elsewhere, by the interrupt identification logic, so this block has no read data for the bus. From each accepted write it drives three things: a single FIFO-mode enable shared by the transmit and receive FIFOs, one-cycle flush strobes for each FIFO, and the receive trigger threshold expressed as a byte count.

Bit 0 of the written byte acts as a gate. A write with bit 0 set turns FIFO mode on and latches the remaining fields. A write with bit 0 clear turns FIFO mode off and flushes both FIFOs. In that case every other bit of the byte is discarded. A shadow copy of the last value that took effect is always visible on a separate runtime read port. There are no DMA request outputs.

Top module: `uart_fifo_ctl`

## Requirements
- R1: Only a write strobe with the address equal to OFFSET (default 2) reaches the register. Writes at any other address leave every output unchanged and raise no flush strobe.
- R2: An accepted write with bit 0 = 1 sets fifo_en to 1.
- R3: An accepted write with bit 0 = 0 clears fifo_en and pulses both rx_flush and tx_flush high for exactly one cycle. This covers leaving FIFO mode, so any switch out of FIFO mode flushes both FIFOs.
- R4: In an accepted write with bit 0 = 0, bits 7..1 are ignored. The trigger level and shadow bits 7..3 keep their previous values.
- R5: Bits 7..6 of the last write with bit 0 = 1 select rx_trig_lvl as follows: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R6: In a write with bit 0 = 1, bit 1 = 1 pulses rx_flush and bit 2 = 1 pulses tx_flush, each for one cycle. Both strobes clear themselves.
- R7: fcr_shadow holds the last effective value. Bit 0 equals fifo_en. Bits 7..3 are as written by the last write with bit 0 = 1. Bits 2..1 always read 0.
- R8: Synchronous reset leaves fifo_en = 0, rx_trig_lvl = 1, fcr_shadow = 0 and both flush strobes at 0.
- R9: All outputs are registered. A write sampled on a clock edge is visible on the outputs right after that edge, and the flush strobes drop after the next edge unless another write raises them again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Register offset of the write |
| wr_data | input | 8 | Written byte |
| fifo_en | output | 1 | FIFO mode enable for both FIFOs |
| rx_flush | output | 1 | One-cycle receive FIFO flush strobe |
| tx_flush | output | 1 | One-cycle transmit FIFO flush strobe |
| rx_trig_lvl | output | 4 | Receive trigger threshold in bytes |
| fcr_shadow | output | 8 | Runtime readback of the last effective value |

## Verification
The assertions assume that wr_en, wr_addr and wr_data are known and stable around each rising edge. They also assume reset is held from time zero until the first edges have passed. The bench drives every input on the falling edge and asserts reset before the first rising edge. Addresses are drawn at random and weighted toward the register offset. Data bytes are fully random, so gated and ungated writes arrive in any order, including back-to-back writes with no idle cycle between them.

// File: rtl/uart_fcr_pkg.sv
package uart_fcr_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned TRIG_W = 4;

    // decoded view of one written byte
    typedef struct packed {
        logic       hit;
        logic [1:0] trig_sel;   // bits 7..6
        logic [2:0] spare;      // bits 5..3, stored only
        logic       tx_clr;     // bit 2
        logic       rx_clr;     // bit 1
        logic       fifo_on;    // bit 0, gate for the rest
    } fcr_req_t;

    typedef enum logic [1:0] {
        TRIG_1  = 2'b00,
        TRIG_4  = 2'b01,
        TRIG_8  = 2'b10,
        TRIG_14 = 2'b11
    } trig_sel_e;

    function automatic fcr_req_t split_byte(input logic hit, input logic [DATA_W-1:0] d);
        fcr_req_t r;
        r.hit      = hit;
        r.trig_sel = d[7:6];
        r.spare    = d[5:3];
        r.tx_clr   = d[2];
        r.rx_clr   = d[1];
        r.fifo_on  = d[0];
        return r;
    endfunction

    function automatic logic [TRIG_W-1:0] trig_bytes(input logic [1:0] sel);
        case (trig_sel_e'(sel))
            TRIG_1:  return TRIG_W'(1);
            TRIG_4:  return TRIG_W'(4);
            TRIG_8:  return TRIG_W'(8);
            default: return TRIG_W'(14);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] build_shadow(input logic [1:0] sel,
                                                       input logic [2:0] spare,
                                                       input logic on);
        return {sel, spare, 2'b00, on};
    endfunction

endpackage

// File: rtl/fcr_decode.sv
module fcr_decode
    import uart_fcr_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned OFFSET = 2
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output fcr_req_t          req
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(OFFSET);

    always_comb begin
        req = split_byte(wr_en && (wr_addr == HIT_ADDR), wr_data);
    end
endmodule

// File: rtl/fcr_state.sv
module fcr_state
    import uart_fcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fcr_req_t          req,
    output logic              fifo_en,
    output logic              rx_flush,
    output logic              tx_flush,
    output logic [1:0]        trig_sel,
    output logic [DATA_W-1:0] shadow
);
    logic [2:0] spare_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_en  <= 1'b0;
            rx_flush <= 1'b0;
            tx_flush <= 1'b0;
            trig_sel <= TRIG_1;
            spare_q  <= '0;
        end else begin
            rx_flush <= 1'b0;
            tx_flush <= 1'b0;
            if (req.hit) begin
                if (req.fifo_on) begin
                    fifo_en  <= 1'b1;
                    trig_sel <= req.trig_sel;
                    spare_q  <= req.spare;
                    rx_flush <= req.rx_clr;
                    tx_flush <= req.tx_clr;
                end else begin
                    // leaving or staying out of FIFO mode empties both sides
                    fifo_en  <= 1'b0;
                    rx_flush <= 1'b1;
                    tx_flush <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        shadow = build_shadow(trig_sel, spare_q, fifo_en);
    end
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import uart_fcr_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned OFFSET = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              fifo_en,
    output logic              rx_flush,
    output logic              tx_flush,
    output logic [3:0]        rx_trig_lvl,
    output logic [7:0]        fcr_shadow
);
    fcr_req_t   req;
    logic [1:0] trig_sel;

    fcr_decode #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .req     (req)
    );

    fcr_state u_state (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .fifo_en  (fifo_en),
        .rx_flush (rx_flush),
        .tx_flush (tx_flush),
        .trig_sel (trig_sel),
        .shadow   (fcr_shadow)
    );

    always_comb begin
        rx_trig_lvl = trig_bytes(trig_sel);
    end
endmodule

// File: rtl/fcr_chk.sv
module fcr_chk #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned OFFSET = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              fifo_en,
    input logic              rx_flush,
    input logic              tx_flush,
    input logic [3:0]        rx_trig_lvl,
    input logic [7:0]        fcr_shadow
);
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(OFFSET));

    assert_flush_needs_write_R1: assert property (@(posedge clk) disable iff (rst)
        (rx_flush || tx_flush) |-> $past(hit));

    assert_mode_needs_write_R1: assert property (@(posedge clk) disable iff (rst)
        !$stable(fifo_en) |-> $past(hit));

    assert_enable_on_set_R2: assert property (@(posedge clk) disable iff (rst)
        hit && wr_data[0] |=> fifo_en);

    assert_leave_flushes_R3: assert property (@(posedge clk) disable iff (rst)
        hit && !wr_data[0] |=> !fifo_en && rx_flush && tx_flush);

    assert_gated_hold_R4: assert property (@(posedge clk) disable iff (rst)
        hit && !wr_data[0] |=> $stable(rx_trig_lvl) && $stable(fcr_shadow[7:3]));

    assert_trig_legal_R5: assert property (@(posedge clk) disable iff (rst)
        rx_trig_lvl == 4'd1 || rx_trig_lvl == 4'd4 || rx_trig_lvl == 4'd8 || rx_trig_lvl == 4'd14);

    assert_strobe_bits_R6: assert property (@(posedge clk) disable iff (rst)
        hit && wr_data[0] |=> (rx_flush == $past(wr_data[1])) && (tx_flush == $past(wr_data[2])));

    assert_shadow_tracks_R7: assert property (@(posedge clk) disable iff (rst)
        fcr_shadow[0] == fifo_en && fcr_shadow[2:1] == 2'b00);

    assert_reset_state_R8: assert property (@(posedge clk)
        $past(rst) && rst |-> !fifo_en && !rx_flush && !tx_flush && fcr_shadow == 8'h00 && rx_trig_lvl == 4'd1);

    assert_strobe_drops_R9: assert property (@(posedge clk) disable iff (rst)
        !hit |=> !rx_flush && !tx_flush);
endmodule

bind uart_fifo_ctl fcr_chk #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_chk (.*);

// File: tb/uart_fifo_ctl_bench.sv
`timescale 1ns/1ps
module uart_fifo_ctl_bench;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned OFFSET = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              fifo_en, rx_flush, tx_flush;
    logic [3:0]        rx_trig_lvl;
    logic [7:0]        fcr_shadow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    bit       m_en;
    bit       m_rxf, m_txf;
    bit [1:0] m_sel;
    bit [2:0] m_spare;

    always #4 clk = ~clk;

    uart_fifo_ctl #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_uart_fifo_ctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fifo_en(fifo_en), .rx_flush(rx_flush), .tx_flush(tx_flush),
        .rx_trig_lvl(rx_trig_lvl), .fcr_shadow(fcr_shadow)
    );

    function automatic bit [3:0] lvl_of(input bit [1:0] s);
        case (s)
            2'b00: return 4'd1;
            2'b01: return 4'd4;
            2'b10: return 4'd8;
            default: return 4'd14;
        endcase
    endfunction

    function automatic bit [7:0] shadow_of();
        return {m_sel, m_spare, 2'b00, m_en};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "fifo_en", int'(fifo_en), int'(m_en));
        chk(req, "rx_flush", int'(rx_flush), int'(m_rxf));
        chk(req, "tx_flush", int'(tx_flush), int'(m_txf));
        chk(req, "rx_trig_lvl", int'(rx_trig_lvl), int'(lvl_of(m_sel)));
        chk(req, "fcr_shadow", int'(fcr_shadow), int'(shadow_of()));
    endtask

    // one bus cycle: drive on falling edge, check after the following rising edge
    task automatic cycle(input bit we, input bit [ADDR_W-1:0] a, input bit [7:0] d, input string req);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_rxf = 1'b0; m_txf = 1'b0;
        if (we && a == ADDR_W'(OFFSET)) begin
            if (d[0]) begin
                m_en = 1'b1; m_sel = d[7:6]; m_spare = d[5:3];
                m_rxf = d[1]; m_txf = d[2];
            end else begin
                m_en = 1'b0; m_rxf = 1'b1; m_txf = 1'b1;
            end
        end
        chk_all(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_en = 0; m_rxf = 0; m_txf = 0; m_sel = 0; m_spare = 0;
        repeat (3) @(negedge clk);
        chk_all("R8");
        @(negedge clk);
        rst = 1'b0;

        // directed
        cycle(1'b1, 3'd2, 8'b0100_0001, "R2");            // enable, trigger 4
        chk(  "R5", "lvl01", int'(rx_trig_lvl), 4);
        cycle(1'b0, 3'd2, 8'h00, "R9");                   // idle, no strobe
        cycle(1'b1, 3'd2, 8'b1000_0111, "R6");            // both strobes, trigger 8
        cycle(1'b1, 3'd2, 8'b1100_0011, "R6");            // rx only, back-to-back
        cycle(1'b1, 3'd2, 8'b0010_1101, "R7");            // tx only, spare bits stored
        cycle(1'b1, 3'd2, 8'b1111_1110, "R4");            // gated: flush, fields kept
        chk(  "R3", "fifo_off", int'(fifo_en), 0);
        cycle(1'b0, 3'd2, 8'h00, "R9");
        cycle(1'b1, 3'd5, 8'b1100_0111, "R1");            // wrong offset
        cycle(1'b1, 3'd2, 8'b1100_0001, "R5");
        chk(  "R5", "lvl11", int'(rx_trig_lvl), 14);
        cycle(1'b1, 3'd2, 8'b0000_0000, "R3");            // leave FIFO mode
        cycle(1'b1, 3'd2, 8'b0000_0000, "R3");            // already off, still flushes
        cycle(1'b1, 3'd2, 8'b0000_0001, "R5");
        chk(  "R5", "lvl00", int'(rx_trig_lvl), 1);

        // random
        for (int i = 0; i < 400; i++) begin
            bit [ADDR_W-1:0] a;
            a = ($urandom % 3 != 0) ? ADDR_W'(OFFSET) : ADDR_W'($urandom);
            cycle(($urandom % 5) != 0, a, 8'($urandom), "R7");
        end

        // reset again mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        m_en = 0; m_rxf = 0; m_txf = 0; m_sel = 0; m_spare = 0;
        chk_all("R8");
        rst = 1'b0;
        finish_run();
    end
endmodule